// File: doc/BRIEF.md
# Phase-Correct PWM Timer

An 8-bit timer counts up from zero to its maximum and back down again, producing a symmetric (phase-correct) pulse-width waveform on one output. The counter advances on timer ticks. A 3-bit clock-select input chooses where the ticks come from: no ticks at all, one tick per system clock, or one tick per 8, 32, 64, 128, 256 or 1024 system clocks, taken from a shared free-running prescaler. At each tick the counter value is compared with an active compare register. A match sets or clears the output register, and the count direction decides which of the two happens.

Software-style write ports load the counter and the compare value, and the counter value can be read back at any time. A compare write lands in a holding register. It becomes active only when the counter leaves its maximum, so a duty-cycle change never tears a period. A 2-bit output-mode input selects disconnected, non-inverting or inverting behaviour. The output-enable flag tells the pin logic whether the waveform drives the pin.

All interfaces are plain control pins with no valid/ready handshake. Every write is accepted in the cycle it is presented, and nothing can exert back-pressure.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset, `cnt_rd` is 0, `pwm_out` is 0, the count direction is up and the active compare value is 0.
- R2: On each tick without a counter write, the counter steps by one. It rises from 0 to 255, turns to 254, falls to 0 and turns to 1, so one period is 510 ticks.
- R3: With `clk_sel` = 000 the counter, the direction, the output and the prescaler all hold. With `clk_sel` = 001 there is one tick per clock.
- R4: `clk_sel` values 010, 011, 100, 101, 110 and 111 give one tick every 8, 32, 64, 128, 256 and 1024 clocks respectively.
- R5: Mode 10 (non-inverting) applies only when the active compare value is below 255. A match seen while counting up clears `pwm_out`, and a match seen while counting down sets it. A match is the counter equal to the compare value at a tick. The counter at 255 counts as down and at 0 as up. In steady state the output is high for 2·C ticks of each 510-tick period.
- R6: Mode 11 (inverting) is the mirror of mode 10. An up-count match sets the output and a down-count match clears it, so the output is high for 510 − 2·C ticks per period.
- R7: With an active compare value of 255 and mode bit 1 set, the normal match is ignored. When the counter leaves 255, mode 10 sets the output and mode 11 clears it, so the output is constantly high in mode 10 and constantly low in mode 11.
- R8: Modes 00 and 01 drive `pwm_oe` low, and the output register keeps its value whatever the counter does. Modes 10 and 11 drive `pwm_oe` high.
- R9: A counter write loads `cnt_wr_data` at the next clock edge, even if a tick falls in the same cycle. The new value is visible on `cnt_rd` after that edge.
- R10: After a counter write, the compare at the next tick is suppressed, so the output does not change on that tick. Compares resume on the tick after.
- R11: A compare write goes to a holding register. The holding register is copied into the active compare register on the tick that moves the counter away from 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Tick source select (000 stop, 001 undivided, 010..111 prescaler taps) |
| out_mode | input | 2 | Output mode: 00/01 disconnected, 10 non-inverting, 11 inverting |
| cnt_wr_en | input | 1 | Load the counter this cycle |
| cnt_wr_data | input | 8 | Value to load into the counter |
| cmp_wr_en | input | 1 | Write the compare holding register this cycle |
| cmp_wr_data | input | 8 | Value for the compare holding register |
| cnt_rd | output | 8 | Current counter value |
| pwm_out | output | 1 | Output waveform register |
| pwm_oe | output | 1 | High when the waveform should drive the pin |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a counter write and a timer tick. The second pair is the copy from the compare holding register and the compare made at 255. With `clk_sel` = 001 every cycle is a tick, so the bench writes the counter in mid-slope to the compare value. It then judges at the pins that the written value appears instead of a step, and that the output does not toggle on the following tick. The bench also writes a new compare value during an up-slope. It checks that the old value still governs the rest of that slope and the new value governs the down-slope after the turn at 255. A compare value of 255 in both active modes checks that the special case at 255 produces a constant output.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  // Prescaler depth: enough bits for the slowest tap.
  localparam int PRE_W  = 10;
  localparam int SEL_W  = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_RSVD   = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } out_mode_e;

  // Number of low prescaler bits that must all be one for a tap to fire.
  function automatic int tap_bits(input int sel);
    case (sel)
      2:       return 3;   // /8
      3:       return 5;   // /32
      4:       return 6;   // /64
      5:       return 7;   // /128
      6:       return 8;   // /256
      7:       return 10;  // /1024
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
  import pcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_SEL-1:0] hit;

  // Free-running divider, paused only while the timer is stopped.
  always_ff @(posedge clk) begin
    if (!rst_n)          pre_q <= '0;
    else if (sel != '0)  pre_q <= pre_q + 1'b1;
  end

  assign hit[0] = 1'b0;
  assign hit[1] = 1'b1;

  for (genvar s = 2; s < NUM_SEL; s++) begin : g_tap
    localparam int W = tap_bits(s);
    assign hit[s] = &pre_q[W-1:0];
  end

  assign tick = hit[sel];

  assert_prescaler_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> $stable(pre_q));

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             step,
  output logic             blk,
  output logic [CNT_W-1:0] ocr
);

  localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TOP_M1 = TOP - 1'b1;
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  logic [CNT_W-1:0] cnt_q, cnt_nx, buf_q, act_q;
  logic             dir_q, eff_up, blk_q;

  // Direction flips at the ends, so a written end value turns correctly.
  always_comb begin
    eff_up = dir_q;
    if (cnt_q == TOP)         eff_up = 1'b0;
    else if (cnt_q == BOTTOM) eff_up = 1'b1;
    cnt_nx = eff_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  assign step = tick && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      blk_q <= 1'b0;
    end else if (wr_en) begin
      cnt_q <= wr_data;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_nx;
      dir_q <= eff_up;
      blk_q <= 1'b0;
    end
  end

  // Double-buffered compare value, promoted when leaving TOP.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (cmp_wr_en)              buf_q <= cmp_wr_data;
      if (step && cnt_q == TOP)   act_q <= buf_q;
    end
  end

  assign cnt = cnt_q;
  assign up  = eff_up;
  assign blk = blk_q;
  assign ocr = act_q;

  assert_step_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q != $past(cnt_q));

  assert_turn_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == TOP) |=> cnt_q == TOP_M1);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));

  assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data));

  assert_buffer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && cnt_q == TOP) |=> $stable(act_q));

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             blk,
  input  logic             up,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ocr,
  input  logic [1:0]       mode,
  output logic             oc,
  output logic             oe
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  out_mode_e m;
  logic      active, do_set, do_clr, oc_q;

  assign m      = out_mode_e'(mode);
  assign active = (m == OM_NONINV) || (m == OM_INV);

  always_comb begin
    do_set = 1'b0;
    do_clr = 1'b0;
    if (step && !blk && active) begin
      if (ocr != TOP) begin
        if (cnt == ocr) begin
          if (up == (m == OM_INV)) do_set = 1'b1;
          else                     do_clr = 1'b1;
        end
      end else if (cnt == TOP) begin
        // Match at TOP ignored; the down-slope action is taken here instead.
        if (m == OM_INV) do_clr = 1'b1;
        else             do_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      oc_q <= 1'b0;
    else if (do_set) oc_q <= 1'b1;
    else if (do_clr) oc_q <= 1'b0;
  end

  assign oc = oc_q;
  assign oe = active;

  assert_disconnect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> $stable(oc_q));

  assert_block_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && blk) |=> $stable(oc_q));

  assert_no_match_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != ocr && cnt != TOP) |=> $stable(oc_q));

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       out_mode,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             pwm_out,
  output logic             pwm_oe
);

  logic             tick, step, blk, up;
  logic [CNT_W-1:0] cnt, ocr;

  pcpwm_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel),
    .tick  (tick)
  );

  pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wr_en       (cnt_wr_en),
    .wr_data     (cnt_wr_data),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .cnt         (cnt),
    .up          (up),
    .step        (step),
    .blk         (blk),
    .ocr         (ocr)
  );

  pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .blk   (blk),
    .up    (up),
    .cnt   (cnt),
    .ocr   (ocr),
    .mode  (out_mode),
    .oc    (pwm_out),
    .oe    (pwm_oe)
  );

  assign cnt_rd = cnt;

endmodule

// File: tb/pcpwm_timer_bench.sv
`timescale 1ns/1ps
module pcpwm_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic [1:0] out_mode;
  logic       cnt_wr_en, cmp_wr_en;
  logic [7:0] cnt_wr_data, cmp_wr_data;
  logic [7:0] cnt_rd;
  logic       pwm_out, pwm_oe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pcpwm_timer u_pcpwm_timer (
    .clk (clk), .rst_n (rst_n), .clk_sel (clk_sel), .out_mode (out_mode),
    .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
    .cmp_wr_en (cmp_wr_en), .cmp_wr_data (cmp_wr_data),
    .cnt_rd (cnt_rd), .pwm_out (pwm_out), .pwm_oe (pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input int v);
    cnt_wr_en = 1'b1; cnt_wr_data = 8'(v);
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    cmp_wr_en = 1'b1; cmp_wr_data = 8'(v);
    @(negedge clk);
    cmp_wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cnt_rd != 8'(v) && n < 3000);
  endtask

  // Cycles until cnt_rd next changes.
  task automatic interval(output int n);
    logic [7:0] v;
    v = cnt_rd; n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cnt_rd == v && n < 3000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int exp_c, n, hi, ratio, stamp;
    bit up;
    logic o;

    rst_n = 1'b0; clk_sel = 3'b000; out_mode = 2'b00;
    cnt_wr_en = 1'b0; cmp_wr_en = 1'b0; cnt_wr_data = '0; cmp_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt_rd == 0, "R1 counter", cnt_rd, 0);
    chk(pwm_out == 0, "R1 output", pwm_out, 0);
    chk(pwm_oe == 0, "R1 enable", pwm_oe, 0);

    // Stopped timer holds; write while stopped.
    repeat (20) @(negedge clk);
    chk(cnt_rd == 0, "R3 stopped", cnt_rd, 0);
    wr_cnt(37);
    chk(cnt_rd == 37, "R9 load stopped", cnt_rd, 37);
    repeat (20) @(negedge clk);
    chk(cnt_rd == 37, "R3 stopped after write", cnt_rd, 37);

    // Count sequence with one tick per clock.
    clk_sel = 3'b001;
    exp_c = 37; up = 1'b1;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (exp_c == 255) up = 1'b0;
      else if (exp_c == 0) up = 1'b1;
      exp_c = up ? exp_c + 1 : exp_c - 1;
      chk(cnt_rd == 8'(exp_c), "R2 sequence", cnt_rd, exp_c);
    end
    wait_cnt(0);
    stamp = 0;
    do begin @(negedge clk); stamp++; end while (cnt_rd != 0 && stamp < 3000);
    chk(stamp == 510, "R2 period", stamp, 510);

    // Prescaler ratios, skipping the first partial interval.
    for (int s = 1; s < 8; s++) begin
      clk_sel = 3'(s);
      ratio = (s == 1) ? 1 : (s == 2) ? 8 : (s == 3) ? 32 : (s == 4) ? 64 :
              (s == 5) ? 128 : (s == 6) ? 256 : 1024;
      interval(n);
      for (int k = 0; k < 2; k++) begin
        interval(n);
        chk(n == ratio, (s == 1) ? "R3 undivided" : "R4 ratio", n, ratio);
      end
    end
    clk_sel = 3'b001;

    // Duty sweep in both active modes.
    for (int m = 2; m < 4; m++) begin
      out_mode = 2'(m);
      for (int c = 0; c <= 255; c += 17) begin
        wr_cmp(c);
        repeat (1100) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 510; i++) begin
          @(negedge clk);
          hi += int'(pwm_out);
        end
        exp_c = (m == 2) ? 2 * c : 510 - 2 * c;
        if (c == 255)   chk(hi == exp_c, "R7 compare at top", hi, exp_c);
        else if (m == 2) chk(hi == exp_c, "R5 duty", hi, exp_c);
        else            chk(hi == exp_c, "R6 duty", hi, exp_c);
        chk(pwm_oe == 1, "R8 enable active", pwm_oe, 1);
      end
    end

    // Counter write suppresses the next compare (mode 10, C=100).
    out_mode = 2'b10;
    wr_cmp(100);
    repeat (1100) @(negedge clk);
    wait_cnt(0); wait_cnt(50);
    chk(pwm_out == 1, "R5 high on up-slope below C", pwm_out, 1);
    wr_cnt(100);
    chk(cnt_rd == 100, "R9 load over tick", cnt_rd, 100);
    @(negedge clk);
    chk(cnt_rd == 101, "R2 step after load", cnt_rd, 101);
    chk(pwm_out == 1, "R10 compare suppressed", pwm_out, 1);
    wait_cnt(0); wait_cnt(101);
    chk(pwm_out == 0, "R10 compare resumes", pwm_out, 0);

    // Double buffering of the compare value.
    wait_cnt(0); wait_cnt(10);
    wr_cmp(200);
    wait_cnt(150);
    chk(pwm_out == 0, "R11 old value on up-slope", pwm_out, 0);
    wait_cnt(255); wait_cnt(150);
    chk(pwm_out == 1, "R11 new value after top", pwm_out, 1);

    // Disconnected modes hold the output register.
    for (int m = 0; m < 2; m++) begin
      out_mode = 2'(m);
      o = pwm_out;
      for (int i = 0; i < 12; i++) begin
        repeat (50) @(negedge clk);
        chk(pwm_oe == 0, "R8 enable off", pwm_oe, 0);
        chk(pwm_out == o, "R8 output held", pwm_out, o);
      end
    end

    // Stopping a running timer.
    out_mode = 2'b10;
    repeat (300) @(negedge clk);
    clk_sel = 3'b000;
    @(negedge clk);
    exp_c = cnt_rd; o = pwm_out;
    repeat (40) @(negedge clk);
    chk(cnt_rd == 8'(exp_c), "R3 hold count", cnt_rd, exp_c);
    chk(pwm_out == o, "R3 hold output", pwm_out, o);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule